// File: doc/BRIEF.md
# Dynamic Warp Formation Pool

After a divergent branch, the threads of one warp head to two different program counters and half of the SIMD lanes sit idle. This block collects such threads into a small pool of forming warps keyed by target PC. Each cycle it can accept the branch outcome of one warp. That outcome has a taken group and a not-taken group, and each group carries a target PC, a per-lane request mask and a thread ID per lane. The block merges each group into the warp that is currently forming for the same PC. A thread always keeps the lane it came from, so no lane crossbar is needed in front of the register banks.

A scheduler slot, signalled by `iss_take`, removes one pool entry per cycle. The entry chosen is the one holding the most threads (majority-first). It is presented with its PC, its lane mask and its per-lane thread IDs. The block tracks only PCs, thread IDs and lane occupancy. Execution, memory and register files lie outside it.

Top module: `dwf_pool`

## Requirements
- R1: After reset the pool is empty: `iss_valid` is 0 and `in_ready` is 1.
- R2: An accepted group whose PC matches the forming entry for that PC writes its free lanes into that entry. The result shows on the issue outputs in the cycle after the accepting clock edge. Within one branch outcome, the taken and not-taken masks never overlap.
- R3: A thread arriving in lane l is stored and issued in lane l. Lane l's thread ID occupies bits [l*TID_W +: TID_W] of `tk_tid`, `nt_tid` and `iss_tid`, and lane l is bit l of every mask.
- R4: Threads whose lane is already taken in the forming entry for their PC go into a newly allocated entry. That new entry then becomes the forming entry for the PC, and later groups for the PC merge into it rather than into the older one.
- R5: When the taken and not-taken groups name the same PC, their lanes are combined into a single entry update.
- R6: `iss_valid` is high exactly when the pool holds an entry. The issue outputs show the entry with the largest thread count, and on a tie the entry with the lowest pool index.
- R7: `in_ready` is high exactly when at least two pool entries are free. An input with `in_valid` high while `in_ready` is low leaves the pool unchanged.
- R8: When `iss_valid` and `iss_take` are both high at a clock edge, the shown entry is freed and its PC mapping removed. A group for that PC accepted at the same edge goes into a new entry. New entries take the lowest free indices, with the taken group served before the not-taken group.
- R9: Lanes of an issued warp whose `iss_mask` bit is 0 carry a thread ID of 0.
- R10: A group with an all-zero mask allocates and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A branch outcome is offered |
| in_ready | output | 1 | Pool can accept a branch outcome this cycle |
| tk_pc | input | PC_W | Target PC of the taken group |
| tk_mask | input | LANES | Lanes requesting the taken PC |
| tk_tid | input | LANES*TID_W | Thread IDs of the taken group, per lane |
| nt_pc | input | PC_W | Target PC of the not-taken group |
| nt_mask | input | LANES | Lanes requesting the not-taken PC |
| nt_tid | input | LANES*TID_W | Thread IDs of the not-taken group, per lane |
| iss_take | input | 1 | Scheduler slot free: remove the shown entry |
| iss_valid | output | 1 | An entry is being shown for issue |
| iss_pc | output | PC_W | PC of the shown entry |
| iss_mask | output | LANES | Occupied lanes of the shown entry |
| iss_tid | output | LANES*TID_W | Per-lane thread IDs of the shown entry |

## Verification
Every result of this block is visible one cycle after its cause. A group accepted at a rising edge, or an entry removed by `iss_take` at a rising edge, changes the issue outputs and `in_ready` right after that edge, because those outputs are decoded combinationally from registered pool state. The bench therefore changes inputs only on falling edges and holds each stimulus across exactly one rising edge. It reads the outputs at the next falling edge, which is the first point where the effect is due and no later one has arrived yet. Stall and same-edge cases are checked in the same way: the cycle after the blocked or colliding edge shows exactly which entry survived.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
   // width needed to hold values 0..n-1, never below one bit
   function automatic int fits_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/dwf_lane_merge.sv
// Finds the forming entry for one group's PC and splits the group
// into lanes that fit there and lanes that need a fresh entry.
module dwf_lane_merge #(
   parameter int LANES = 4,
   parameter int NE    = 4,
   parameter int PC_W  = 16,
   localparam int IDX_W = dwf_pkg::fits_w(NE)
) (
   input  logic [PC_W-1:0]             grp_pc,
   input  logic [LANES-1:0]            grp_mask,
   input  logic [NE-1:0]               ent_valid,
   input  logic [NE-1:0]               ent_open,
   input  logic [NE-1:0]               excl,
   input  logic [NE-1:0][PC_W-1:0]     ent_pc,
   input  logic [NE-1:0][LANES-1:0]    ent_occ,
   output logic                        hit,
   output logic [IDX_W-1:0]            hit_idx,
   output logic [LANES-1:0]            fit,
   output logic [LANES-1:0]            rest
);
   logic [LANES-1:0] occ_sel;

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int e = 0; e < NE; e++) begin
         if (!hit && ent_valid[e] && ent_open[e] && !excl[e] &&
             ent_pc[e] == grp_pc && grp_mask != '0) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(e);
         end
      end
      occ_sel = ent_occ[hit_idx];
      fit     = hit ? (grp_mask & ~occ_sel) : '0;
      rest    = grp_mask & ~fit;
   end
endmodule

// File: rtl/dwf_free_pick.sv
// Lowest two free pool indices and the number of free entries.
module dwf_free_pick #(
   parameter int NE = 4,
   localparam int IDX_W = dwf_pkg::fits_w(NE),
   localparam int FC_W  = dwf_pkg::fits_w(NE + 1)
) (
   input  logic [NE-1:0]    ent_valid,
   output logic [IDX_W-1:0] idx0,
   output logic [IDX_W-1:0] idx1,
   output logic [FC_W-1:0]  free_cnt
);
   logic got0, got1;

   always_comb begin
      idx0     = '0;
      idx1     = '0;
      got0     = 1'b0;
      got1     = 1'b0;
      free_cnt = '0;
      for (int e = 0; e < NE; e++) begin
         if (!ent_valid[e]) begin
            free_cnt = free_cnt + FC_W'(1);
            if (!got0) begin
               got0 = 1'b1;
               idx0 = IDX_W'(e);
            end else if (!got1) begin
               got1 = 1'b1;
               idx1 = IDX_W'(e);
            end
         end
      end
   end
endmodule

// File: rtl/dwf_majority.sv
// Picks the valid entry with the most occupied lanes; ties go low.
module dwf_majority #(
   parameter int NE    = 4,
   parameter int LANES = 4,
   parameter int CNT_W = 4,
   localparam int IDX_W = dwf_pkg::fits_w(NE)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NE-1:0]            ent_valid,
   input  logic [NE-1:0][LANES-1:0] ent_occ,
   output logic                     sel_valid,
   output logic [IDX_W-1:0]         sel_idx,
   output logic [CNT_W-1:0]         sel_cnt
);
   logic [NE-1:0][CNT_W-1:0] cnt;

   for (genvar e = 0; e < NE; e++) begin : g_cnt
      assign cnt[e] = CNT_W'($countones(ent_occ[e]));
   end

   always_comb begin
      sel_valid = 1'b0;
      sel_idx   = '0;
      sel_cnt   = '0;
      for (int e = 0; e < NE; e++) begin
         if (ent_valid[e] && (!sel_valid || cnt[e] > sel_cnt)) begin
            sel_valid = 1'b1;
            sel_idx   = IDX_W'(e);
            sel_cnt   = cnt[e];
         end
      end
   end

   // R6: a live entry always holds at least one thread
   a_r6_issue_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> sel_cnt != '0);
endmodule

// File: rtl/dwf_pool.sv
module dwf_pool #(
   parameter int LANES = 4,
   parameter int TID_W = 8,
   parameter int PC_W  = 16,
   parameter int NE    = 4,
   localparam int IDX_W = dwf_pkg::fits_w(NE),
   localparam int FC_W  = dwf_pkg::fits_w(NE + 1),
   localparam int CNT_W = dwf_pkg::fits_w(NE * LANES + 2 * LANES + 1) + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [PC_W-1:0]        tk_pc,
   input  logic [LANES-1:0]       tk_mask,
   input  logic [LANES*TID_W-1:0] tk_tid,
   input  logic [PC_W-1:0]        nt_pc,
   input  logic [LANES-1:0]       nt_mask,
   input  logic [LANES*TID_W-1:0] nt_tid,
   input  logic                   iss_take,
   output logic                   iss_valid,
   output logic [PC_W-1:0]        iss_pc,
   output logic [LANES-1:0]       iss_mask,
   output logic [LANES*TID_W-1:0] iss_tid
);
   if (NE < 2) begin : g_bad_ne
      $error("dwf_pool: NE must be at least 2");
   end
   if (LANES < 1 || TID_W < 1 || PC_W < 1) begin : g_bad_w
      $error("dwf_pool: widths must be positive");
   end

   // pool state
   logic [NE-1:0]                        ent_valid, ent_open;
   logic [NE-1:0][PC_W-1:0]              ent_pc;
   logic [NE-1:0][LANES-1:0]             ent_occ;
   logic [NE-1:0][LANES-1:0][TID_W-1:0]  ent_tid;

   // incoming groups after same-PC folding (0 = taken, 1 = not taken)
   logic                                 accept, same_pc;
   logic [1:0][PC_W-1:0]                 g_pc;
   logic [1:0][LANES-1:0]                g_mask, fit, rest;
   logic [1:0][LANES-1:0][TID_W-1:0]     g_tid;
   logic [1:0]                           hit, need;
   logic [1:0][IDX_W-1:0]                hit_idx, alloc_idx;

   // issue side
   logic                                 sel_valid, do_iss;
   logic [IDX_W-1:0]                     sel_idx, free0, free1;
   logic [CNT_W-1:0]                     sel_cnt;
   logic [FC_W-1:0]                      free_cnt;
   logic [NE-1:0]                        excl;

   assign in_ready = free_cnt >= FC_W'(2);
   assign accept   = in_valid && in_ready;
   assign same_pc  = tk_pc == nt_pc;

   always_comb begin
      g_pc[0]   = tk_pc;
      g_pc[1]   = nt_pc;
      g_mask[0] = accept ? (tk_mask | (same_pc ? nt_mask : '0)) : '0;
      g_mask[1] = (accept && !same_pc) ? nt_mask : '0;
      for (int l = 0; l < LANES; l++) begin
         g_tid[0][l] = (same_pc && nt_mask[l]) ? nt_tid[l*TID_W +: TID_W]
                                               : tk_tid[l*TID_W +: TID_W];
         g_tid[1][l] = nt_tid[l*TID_W +: TID_W];
      end
   end

   dwf_majority #(.NE(NE), .LANES(LANES), .CNT_W(CNT_W)) u_major (
      .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_occ(ent_occ),
      .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_cnt(sel_cnt));

   dwf_free_pick #(.NE(NE)) u_free (
      .ent_valid(ent_valid), .idx0(free0), .idx1(free1), .free_cnt(free_cnt));

   assign do_iss = iss_take && sel_valid;
   always_comb begin
      excl = '0;
      if (do_iss) excl[sel_idx] = 1'b1;
   end

   for (genvar g = 0; g < 2; g++) begin : g_grp
      dwf_lane_merge #(.LANES(LANES), .NE(NE), .PC_W(PC_W)) u_merge (
         .grp_pc(g_pc[g]), .grp_mask(g_mask[g]), .ent_valid(ent_valid),
         .ent_open(ent_open), .excl(excl), .ent_pc(ent_pc), .ent_occ(ent_occ),
         .hit(hit[g]), .hit_idx(hit_idx[g]), .fit(fit[g]), .rest(rest[g]));
      assign need[g] = rest[g] != '0;
   end

   // taken group takes the lowest free slot; not-taken takes the next one
   assign alloc_idx[0] = free0;
   assign alloc_idx[1] = need[0] ? free1 : free0;

   for (genvar e = 0; e < NE; e++) begin : g_ent
      logic                        n_valid, n_open;
      logic [PC_W-1:0]             n_pc;
      logic [LANES-1:0]            n_occ;
      logic [LANES-1:0][TID_W-1:0] n_tid;

      always_comb begin
         n_valid = ent_valid[e];
         n_open  = ent_open[e];
         n_pc    = ent_pc[e];
         n_occ   = ent_occ[e];
         n_tid   = ent_tid[e];
         if (excl[e]) begin
            n_valid = 1'b0;
            n_open  = 1'b0;
            n_occ   = '0;
            n_tid   = '0;
         end
         for (int g = 0; g < 2; g++) begin
            if (need[g] && alloc_idx[g] == IDX_W'(e)) begin
               n_valid = 1'b1;
               n_open  = 1'b1;
               n_pc    = g_pc[g];
               n_occ   = rest[g];
               for (int l = 0; l < LANES; l++)
                  n_tid[l] = rest[g][l] ? g_tid[g][l] : '0;
            end else if (hit[g] && hit_idx[g] == IDX_W'(e)) begin
               n_occ = n_occ | fit[g];
               for (int l = 0; l < LANES; l++)
                  if (fit[g][l]) n_tid[l] = g_tid[g][l];
               if (need[g]) n_open = 1'b0;
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_valid[e] <= 1'b0;
            ent_open[e]  <= 1'b0;
            ent_pc[e]    <= '0;
            ent_occ[e]   <= '0;
            ent_tid[e]   <= '0;
         end else begin
            ent_valid[e] <= n_valid;
            ent_open[e]  <= n_open;
            ent_pc[e]    <= n_pc;
            ent_occ[e]   <= n_occ;
            ent_tid[e]   <= n_tid;
         end
      end

      for (genvar l = 0; l < LANES; l++) begin : g_lane
         // R9: an unoccupied lane never carries a stale thread ID
         a_r9_empty_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !ent_occ[e][l] |-> ent_tid[e][l] == '0);
      end
   end

   assign iss_valid = sel_valid;
   assign iss_pc    = ent_pc[sel_idx];
   assign iss_mask  = ent_occ[sel_idx];
   assign iss_tid   = ent_tid[sel_idx];

   // thread accounting for the checks below
   logic [CNT_W-1:0] occ_total, acc_cnt, iss_cnt;
   assign occ_total = CNT_W'($countones(ent_occ));
   assign acc_cnt   = CNT_W'($countones(g_mask));
   assign iss_cnt   = do_iss ? sel_cnt : '0;

   // R3: threads are neither lost nor duplicated while regrouping
   a_r3_threads_conserved: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> occ_total == $past(occ_total + acc_cnt - iss_cnt));

   // R7: a refused branch outcome leaves the pool untouched
   a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready && !iss_take) |=> ($stable(ent_occ) && $stable(ent_valid)));

   // R2: an accepted non-empty outcome is visible one cycle later
   a_r2_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (tk_mask | nt_mask) != '0) |=> iss_valid);
endmodule

// File: tb/dwf_pool_test.sv
`timescale 1ns/1ps
module dwf_pool_test;
   localparam int LANES = 4, TID_W = 8, PC_W = 16, NE = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, iss_take = 1'b0;
   logic [PC_W-1:0] tk_pc = '0, nt_pc = '0;
   logic [LANES-1:0] tk_mask = '0, nt_mask = '0;
   logic [LANES*TID_W-1:0] tk_tid = '0, nt_tid = '0;
   logic in_ready, iss_valid;
   logic [PC_W-1:0] iss_pc;
   logic [LANES-1:0] iss_mask;
   logic [LANES*TID_W-1:0] iss_tid;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   dwf_pool #(.LANES(LANES), .TID_W(TID_W), .PC_W(PC_W), .NE(NE)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .tk_pc(tk_pc), .tk_mask(tk_mask), .tk_tid(tk_tid),
      .nt_pc(nt_pc), .nt_mask(nt_mask), .nt_tid(nt_tid),
      .iss_take(iss_take), .iss_valid(iss_valid), .iss_pc(iss_pc),
      .iss_mask(iss_mask), .iss_tid(iss_tid));

   function automatic logic [31:0] tids(input logic [7:0] t3, t2, t1, t0);
      return {t3, t2, t1, t0};
   endfunction

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      in_valid = 1'b0; iss_take = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // drives one branch outcome across a single rising edge
   task automatic send(input logic [15:0] tp, input logic [3:0] tm, input logic [31:0] tt,
                       input logic [15:0] np, input logic [3:0] nm, input logic [31:0] nt);
      tk_pc = tp; tk_mask = tm; tk_tid = tt;
      nt_pc = np; nt_mask = nm; nt_tid = nt;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic take();
      iss_take = 1'b1;
      @(negedge clk);
      iss_take = 1'b0;
   endtask

   task automatic see(input string req, input logic [15:0] pc, input logic [3:0] m,
                      input logic [31:0] t);
      chk({req, " valid"}, 64'(iss_valid), 64'(1));
      chk({req, " pc"}, 64'(iss_pc), 64'(pc));
      chk({req, " mask"}, 64'(iss_mask), 64'(m));
      chk({req, " tid"}, 64'(iss_tid), 64'(t));
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 iss_valid", 64'(iss_valid), 64'(0));
      chk("R1 in_ready", 64'(in_ready), 64'(1));
   endtask

   task automatic t_split();
      do_reset();
      send(16'h0100, 4'b1001, tids(4, 0, 0, 1), 16'h0200, 4'b0110, tids(0, 3, 2, 0));
      see("R8 taken first / R9 zero lanes", 16'h0100, 4'b1001, tids(4, 0, 0, 1));
      take();
      see("R3 lanes kept", 16'h0200, 4'b0110, tids(0, 3, 2, 0));
      take();
      chk("R8 freed", 64'(iss_valid), 64'(0));
   endtask

   task automatic t_merge();
      do_reset();
      send(16'h0100, 4'b1001, tids(4, 0, 0, 1), 16'h0000, 4'b0000, '0);
      send(16'h0100, 4'b0110, tids(0, 7, 6, 0), 16'h0000, 4'b0000, '0);
      see("R2 merge", 16'h0100, 4'b1111, tids(4, 7, 6, 1));
      take();
      chk("R2 single entry", 64'(iss_valid), 64'(0));
   endtask

   task automatic t_conflict();
      do_reset();
      send(16'h0300, 4'b1001, tids(4, 0, 0, 1), 16'h0000, 4'b0000, '0);
      send(16'h0300, 4'b0011, tids(0, 0, 6, 5), 16'h0000, 4'b0000, '0);
      send(16'h0300, 4'b0100, tids(0, 7, 0, 0), 16'h0000, 4'b0000, '0);
      see("R4 old entry", 16'h0300, 4'b1011, tids(4, 0, 6, 1));
      take();
      see("R4 new forming entry", 16'h0300, 4'b0101, tids(0, 7, 0, 5));
      take();
      chk("R4 drained", 64'(iss_valid), 64'(0));
   endtask

   task automatic t_same();
      do_reset();
      send(16'h0400, 4'b0011, tids(0, 0, 2, 1), 16'h0400, 4'b1100, tids(4, 3, 0, 0));
      see("R5 combined", 16'h0400, 4'b1111, tids(4, 3, 2, 1));
      take();
      chk("R5 one entry", 64'(iss_valid), 64'(0));
   endtask

   task automatic t_majority();
      do_reset();
      send(16'h0500, 4'b0001, tids(0, 0, 0, 1), 16'h0600, 4'b0110, tids(0, 3, 2, 0));
      see("R6 largest", 16'h0600, 4'b0110, tids(0, 3, 2, 0));
      send(16'h0700, 4'b0011, tids(0, 0, 9, 8), 16'h0000, 4'b0000, '0);
      see("R6 tie lowest index", 16'h0600, 4'b0110, tids(0, 3, 2, 0));
      take();
      see("R6 next largest", 16'h0700, 4'b0011, tids(0, 0, 9, 8));
   endtask

   task automatic t_stall();
      do_reset();
      send(16'h0800, 4'b0001, tids(0, 0, 0, 1), 16'h0900, 4'b0010, tids(0, 0, 2, 0));
      chk("R7 ready two free", 64'(in_ready), 64'(1));
      send(16'h0a00, 4'b0100, tids(0, 3, 0, 0), 16'h0000, 4'b0000, '0);
      chk("R7 not ready one free", 64'(in_ready), 64'(0));
      send(16'h0b00, 4'b1111, tids(9, 9, 9, 9), 16'h0000, 4'b0000, '0);
      see("R7 refused input ignored", 16'h0800, 4'b0001, tids(0, 0, 0, 1));
      chk("R7 still not ready", 64'(in_ready), 64'(0));
      take();
      chk("R7 ready after free", 64'(in_ready), 64'(1));
      see("R7 next entry", 16'h0900, 4'b0010, tids(0, 0, 2, 0));
   endtask

   task automatic t_same_edge();
      do_reset();
      send(16'h0c00, 4'b0011, tids(0, 0, 2, 1), 16'h0000, 4'b0000, '0);
      iss_take = 1'b1;
      send(16'h0c00, 4'b1100, tids(4, 3, 0, 0), 16'h0000, 4'b0000, '0);
      iss_take = 1'b0;
      see("R8 same-edge arrival kept", 16'h0c00, 4'b1100, tids(4, 3, 0, 0));
      take();
      chk("R8 mapping cleared", 64'(iss_valid), 64'(0));
   endtask

   task automatic t_empty();
      do_reset();
      send(16'h0d00, 4'b0000, tids(1, 1, 1, 1), 16'h0e00, 4'b0000, tids(2, 2, 2, 2));
      chk("R10 no entry", 64'(iss_valid), 64'(0));
      chk("R10 ready kept", 64'(in_ready), 64'(1));
      send(16'h0d00, 4'b0010, tids(0, 0, 5, 0), 16'h0e00, 4'b0000, tids(2, 2, 2, 2));
      see("R10 one group only", 16'h0d00, 4'b0010, tids(0, 0, 5, 0));
      take();
      chk("R10 nothing for empty group", 64'(iss_valid), 64'(0));
   endtask

   initial begin
      t_reset();
      t_split();
      t_merge();
      t_conflict();
      t_same();
      t_majority();
      t_stall();
      t_same_edge();
      t_empty();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule